// File: doc/BRIEF.md
# Dynamic Bus Sizing Controller

This block sits between an internal master and an external 16-bit data bus. The master issues a one-cycle request for a byte or a 16-bit word, either read or write. The controller then runs one or more strobed bus cycles and answers with a one-cycle completion pulse. For reads, that pulse carries the assembled data.

The width of the responding port is never configured. On every bus cycle the controller learns it from which of two active-low end-of-cycle inputs the port pulls low: one means a byte-wide port, the other a word-wide port. Byte-wide ports hang on data lines 15:8 only. When a word access is answered by a byte-wide port, the controller releases the strobe for one clock and runs a second cycle at the next (odd) address. It builds the word from the two upper-lane bytes.

The bus waits until the port ends each cycle. A fixed address region can instead be ended by an internal acknowledge after a programmed number of clocks, so simple devices there need no acknowledge logic. A cycle that nobody ends is aborted after a clock limit, and an error flag goes back to the master.

Top module: `sizing_bus_ctrl`

## Requirements
- R1: A cycle ended by `end16_n` low (sampled at a rising edge) is a word-port cycle. A word read then completes in one bus cycle with `rdata` equal to `bus_din[15:0]`.
- R2: A word access ended by `end8_n` alone runs a second bus cycle at the odd address. The first cycle's `bus_din[15:8]` becomes `rdata[15:8]`, and the second cycle's `bus_din[15:8]` becomes `rdata[7:0]`.
- R3: A byte read returns its byte in `rdata[7:0]` with `rdata[15:8]` zero. The byte is taken from lines 15:8 when the port is byte-wide. From a word-wide port it is taken from 15:8 for an even address and from 7:0 for an odd address.
- R4: `bus_dout` is driven (`bus_doe` high) only during write strobes. A byte write puts the byte on both halves. A word write drives `{hi,lo}` in its first cycle and `{lo,lo}` in the second cycle, if one occurs.
- R5: When both end inputs are low in the same sample, the cycle is treated as a word-port cycle.
- R6: Each rising edge with the strobe active and no end input adds one clock. `done` rises one clock after the edge that samples the end, so with a port that ends w clocks late a single-cycle access takes w+2 clocks from the request.
- R7: In the region where `(addr & RGN_MASK) == RGN_BASE`, `bus_cs_n` is low during the strobe. When `cfg_iack_en` is high, the cycle ends as a word-port cycle at the edge where the wait counter equals `cfg_iack_wait` (0 to 15), and both external end inputs are ignored.
- R8: A bus cycle with no end for TMO_CYC (64) edges is aborted. `done` and `berr` pulse together, `rdata` is zero, and the controller returns to idle.
- R9: A request that arrives while a transfer is in progress is ignored.
- R10: After reset, and between transfers, the strobe is high and `done` is low. `done` is a single-clock pulse.
- R11: A word access ignores `req_addr[0]`, and its first bus cycle uses the even address.
- R12: The strobe is high for exactly one clock between the two halves of a split word access. The address stays stable while the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | One-cycle transfer request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte |
| req_addr | input | AW | Byte address |
| req_wdata | input | 16 | Write data (byte in bits 7:0) |
| cfg_iack_en | input | 1 | Enable internal acknowledge for the region |
| cfg_iack_wait | input | 4 | Internal acknowledge wait count |
| done | output | 1 | Transfer complete pulse |
| rdata | output | 16 | Assembled read data, valid with done |
| berr | output | 1 | Timeout error, pulses with done |
| bus_addr | output | AW | External address |
| bus_strb_n | output | 1 | Active-low cycle strobe |
| bus_rd | output | 1 | 1 = read cycle |
| bus_dout | output | 16 | Write data lines |
| bus_doe | output | 1 | Write data drive enable |
| bus_cs_n | output | 1 | Active-low region select |
| bus_din | input | 16 | Read data lines |
| end8_n | input | 1 | Active-low end from a byte-wide port |
| end16_n | input | 1 | Active-low end from a word-wide port |

## Verification
The bench's device model returns the same bytes from a byte-wide and a word-wide port, and it puts junk on the unused lower lane of a byte port. Any mis-steered lane therefore shows up as wrong read data, as does a swapped upper/lower byte in a split word or a second cycle taken from lines 7:0. Latency is measured for each transfer. A missing wait state, a missing gap clock, an internal acknowledge that obeys an external strobe, or an off-by-one timeout each shifts `done` by at least one clock. Write data is captured at every bus cycle, which catches a byte that is not mirrored onto both halves and a second word half that carries the wrong byte. Busy-time requests and simultaneous end inputs are also exercised: a design that took the extra request or picked the byte width would add a bus cycle.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACT  = 2'd1,
        ST_GAP  = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        END_NONE = 2'd0,
        END_BYTE = 2'd1,
        END_WORD = 2'd2,
        END_TMO  = 2'd3
    } cyc_end_e;

    typedef struct packed {
        logic we;
        logic word;
        logic phase;
    } xfer_ctl_t;

    // The word strobe wins when both are seen together.
    function automatic cyc_end_e width_from_strobes(input logic e8_n, input logic e16_n);
        if (!e16_n)     return END_WORD;
        else if (!e8_n) return END_BYTE;
        else            return END_NONE;
    endfunction

    function automatic logic [15:0] dup_byte(input logic [7:0] b);
        return {b, b};
    endfunction

endpackage

// File: rtl/sbc_region.sv
module sbc_region #(
    parameter int            AW   = 16,
    parameter logic [AW-1:0] BASE = '0,
    parameter logic [AW-1:0] MASK = '0
) (
    input  logic [AW-1:0] addr,
    output logic          in_rgn
);
    assign in_rgn = ((addr & MASK) == BASE);
endmodule

// File: rtl/sbc_term.sv
module sbc_term
    import sbc_pkg::*;
#(
    parameter int TMO_CYC = 64,
    parameter int CW      = 6
) (
    input  logic          active,
    input  logic          in_rgn,
    input  logic          iack_en,
    input  logic [3:0]    iack_wait,
    input  logic          e8_n,
    input  logic          e16_n,
    input  logic [CW-1:0] wcnt,
    output cyc_end_e      end_kind
);
    logic internal;
    assign internal = in_rgn && iack_en;

    always_comb begin
        end_kind = END_NONE;
        if (active) begin
            if (internal) begin
                if (wcnt == CW'(iack_wait)) end_kind = END_WORD;
            end else begin
                end_kind = width_from_strobes(e8_n, e16_n);
            end
            if (end_kind == END_NONE && wcnt == CW'(TMO_CYC - 1))
                end_kind = END_TMO;
        end
    end
endmodule

// File: rtl/sbc_lanes.sv
module sbc_lanes
    import sbc_pkg::*;
(
    input  xfer_ctl_t   ctl,
    input  logic        odd,
    input  cyc_end_e    end_kind,
    input  logic [15:0] wdata,
    input  logic [15:0] din,
    input  logic [7:0]  hi_q,
    output logic [15:0] dout,
    output logic [7:0]  lane_byte,
    output logic [15:0] rdata_asm
);
    // Write lanes: mirrored byte, or the word then its low byte mirrored.
    always_comb begin
        if (!ctl.word || ctl.phase) dout = dup_byte(wdata[7:0]);
        else                        dout = wdata;
    end

    // Byte-wide ports always answer on 15:8.
    always_comb begin
        if (end_kind == END_BYTE) lane_byte = din[15:8];
        else if (odd)             lane_byte = din[7:0];
        else                      lane_byte = din[15:8];
    end

    always_comb begin
        if (!ctl.word)     rdata_asm = {8'h00, lane_byte};
        else if (ctl.phase) rdata_asm = {hi_q, lane_byte};
        else               rdata_asm = din;
    end
endmodule

// File: rtl/sbc_seq.sv
module sbc_seq
    import sbc_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic          req_we,
    input  logic          req_word,
    input  logic [AW-1:0] req_addr,
    input  logic [15:0]   req_wdata,
    input  cyc_end_e      end_kind,
    input  logic [7:0]    lane_byte,
    input  logic [15:0]   rdata_asm,
    output logic          active,
    output logic [AW-1:0] addr_q,
    output xfer_ctl_t     ctl,
    output logic [15:0]   wdata_q,
    output logic [CW-1:0] wcnt,
    output logic [7:0]    hi_q,
    output logic          done,
    output logic [15:0]   rdata,
    output logic          berr
);
    seq_state_e state;

    assign active = (state == ST_ACT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            addr_q  <= '0;
            ctl     <= '0;
            wdata_q <= '0;
            wcnt    <= '0;
            hi_q    <= '0;
            done    <= 1'b0;
            rdata   <= '0;
            berr    <= 1'b0;
        end else begin
            done <= 1'b0;
            berr <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req) begin
                        ctl.we    <= req_we;
                        ctl.word  <= req_word;
                        ctl.phase <= 1'b0;
                        addr_q    <= req_word ? {req_addr[AW-1:1], 1'b0} : req_addr;
                        wdata_q   <= req_wdata;
                        wcnt      <= '0;
                        state     <= ST_ACT;
                    end
                end
                ST_ACT: begin
                    case (end_kind)
                        END_NONE: wcnt <= wcnt + 1'b1;
                        END_TMO: begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                            berr  <= 1'b1;
                            rdata <= '0;
                        end
                        END_BYTE: begin
                            if (ctl.word && !ctl.phase) begin
                                hi_q      <= lane_byte;
                                ctl.phase <= 1'b1;
                                addr_q[0] <= 1'b1;
                                wcnt      <= '0;
                                state     <= ST_GAP;
                            end else begin
                                state <= ST_IDLE;
                                done  <= 1'b1;
                                rdata <= ctl.we ? 16'h0000 : rdata_asm;
                            end
                        end
                        default: begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                            rdata <= ctl.we ? 16'h0000 : rdata_asm;
                        end
                    endcase
                end
                ST_GAP:  state <= ST_ACT;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sizing_bus_ctrl.sv
module sizing_bus_ctrl
    import sbc_pkg::*;
#(
    parameter int            AW       = 16,
    parameter int            TMO_CYC  = 64,
    parameter logic [AW-1:0] RGN_BASE = 16'hF000,
    parameter logic [AW-1:0] RGN_MASK = 16'hF000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic          req_we,
    input  logic          req_word,
    input  logic [AW-1:0] req_addr,
    input  logic [15:0]   req_wdata,
    input  logic          cfg_iack_en,
    input  logic [3:0]    cfg_iack_wait,
    output logic          done,
    output logic [15:0]   rdata,
    output logic          berr,
    output logic [AW-1:0] bus_addr,
    output logic          bus_strb_n,
    output logic          bus_rd,
    output logic [15:0]   bus_dout,
    output logic          bus_doe,
    output logic          bus_cs_n,
    input  logic [15:0]   bus_din,
    input  logic          end8_n,
    input  logic          end16_n
);
    localparam int CW = $clog2(TMO_CYC);

    logic          active;
    logic [AW-1:0] addr_q;
    xfer_ctl_t     ctl;
    logic [15:0]   wdata_q;
    logic [CW-1:0] wcnt;
    logic [7:0]    hi_q;
    logic          in_rgn;
    cyc_end_e      end_kind;
    logic [7:0]    lane_byte;
    logic [15:0]   rdata_asm;

    sbc_region #(.AW(AW), .BASE(RGN_BASE), .MASK(RGN_MASK)) u_region (
        .addr   (addr_q),
        .in_rgn (in_rgn)
    );

    sbc_term #(.TMO_CYC(TMO_CYC), .CW(CW)) u_term (
        .active    (active),
        .in_rgn    (in_rgn),
        .iack_en   (cfg_iack_en),
        .iack_wait (cfg_iack_wait),
        .e8_n      (end8_n),
        .e16_n     (end16_n),
        .wcnt      (wcnt),
        .end_kind  (end_kind)
    );

    sbc_lanes u_lanes (
        .ctl       (ctl),
        .odd       (addr_q[0]),
        .end_kind  (end_kind),
        .wdata     (wdata_q),
        .din       (bus_din),
        .hi_q      (hi_q),
        .dout      (bus_dout),
        .lane_byte (lane_byte),
        .rdata_asm (rdata_asm)
    );

    sbc_seq #(.AW(AW), .CW(CW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .req_we    (req_we),
        .req_word  (req_word),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .end_kind  (end_kind),
        .lane_byte (lane_byte),
        .rdata_asm (rdata_asm),
        .active    (active),
        .addr_q    (addr_q),
        .ctl       (ctl),
        .wdata_q   (wdata_q),
        .wcnt      (wcnt),
        .hi_q      (hi_q),
        .done      (done),
        .rdata     (rdata),
        .berr      (berr)
    );

    assign bus_addr   = addr_q;
    assign bus_strb_n = !active;
    assign bus_rd     = !ctl.we;
    assign bus_doe    = active && ctl.we;
    assign bus_cs_n   = !(active && in_rgn);
endmodule

// File: rtl/sbc_chk.sv
module sbc_chk #(
    parameter int AW      = 16,
    parameter int TMO_CYC = 64
) (
    input logic          clk,
    input logic          rst,
    input logic          done,
    input logic          berr,
    input logic [AW-1:0] bus_addr,
    input logic          bus_strb_n,
    input logic          bus_rd,
    input logic          bus_doe,
    input logic          bus_cs_n
);
    localparam int RW = $clog2(TMO_CYC + 2) + 1;
    logic [RW-1:0] strb_run;

    always_ff @(posedge clk) begin
        if (rst)              strb_run <= '0;
        else if (!bus_strb_n) strb_run <= strb_run + 1'b1;
        else                  strb_run <= '0;
    end

    AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10
    AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> bus_strb_n); // R10
    AST_BERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        berr |-> done); // R8
    AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (rst)
        strb_run <= RW'(TMO_CYC)); // R8
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (!bus_strb_n && !$past(bus_strb_n)) |-> $stable(bus_addr)); // R12
    AST_CS_IN_STROBE: assert property (@(posedge clk) disable iff (rst)
        !bus_cs_n |-> !bus_strb_n); // R7
    AST_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        bus_doe |-> (!bus_strb_n && !bus_rd)); // R4
endmodule

bind sizing_bus_ctrl sbc_chk #(.AW(AW), .TMO_CYC(TMO_CYC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .done       (done),
    .berr       (berr),
    .bus_addr   (bus_addr),
    .bus_strb_n (bus_strb_n),
    .bus_rd     (bus_rd),
    .bus_doe    (bus_doe),
    .bus_cs_n   (bus_cs_n)
);

// File: tb/sizing_bus_ctrl_bench.sv
module sizing_bus_ctrl_bench;

    typedef struct packed {
        logic        we;
        logic        word;
        logic [15:0] addr;
        logic [15:0] wdata;
        logic [1:0]  mode;   // 0 byte port, 1 word port, 2 both strobes, 3 silent
        logic [3:0]  wt;
        logic        iack;
        logic [3:0]  iwt;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 16'h0100, 16'h0000, 2'd1, 4'd0, 1'b0, 4'd0},
        '{1'b0, 1'b1, 16'h0201, 16'h0000, 2'd0, 4'd1, 1'b0, 4'd0},
        '{1'b0, 1'b0, 16'h0305, 16'h0000, 2'd1, 4'd2, 1'b0, 4'd0},
        '{1'b0, 1'b0, 16'h0304, 16'h0000, 2'd0, 4'd0, 1'b0, 4'd0},
        '{1'b0, 1'b1, 16'h0410, 16'h0000, 2'd2, 4'd3, 1'b0, 4'd0},
        '{1'b1, 1'b0, 16'h0507, 16'h00C3, 2'd1, 4'd0, 1'b0, 4'd0},
        '{1'b1, 1'b1, 16'h0600, 16'hA55A, 2'd0, 4'd1, 1'b0, 4'd0},
        '{1'b1, 1'b1, 16'h0702, 16'h1234, 2'd1, 4'd0, 1'b0, 4'd0},
        '{1'b0, 1'b1, 16'hF020, 16'h0000, 2'd3, 4'd0, 1'b1, 4'd5},
        '{1'b0, 1'b1, 16'hF040, 16'h0000, 2'd2, 4'd0, 1'b1, 4'd4},
        '{1'b0, 1'b1, 16'h0800, 16'h0000, 2'd3, 4'd0, 1'b0, 4'd0},
        '{1'b0, 1'b0, 16'hF003, 16'h0000, 2'd3, 4'd0, 1'b1, 4'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic        req_word = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        cfg_iack_en = 1'b0;
    logic [3:0]  cfg_iack_wait = '0;
    logic        done, berr, bus_strb_n, bus_rd, bus_doe, bus_cs_n;
    logic [15:0] rdata, bus_addr, bus_dout, bus_din;
    logic        end8_n = 1'b1;
    logic        end16_n = 1'b1;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    int mode = 1;
    int mwait = 0;
    int dcnt = 0;
    int ncap = 0;
    logic [15:0] cap_addr [4];
    logic [15:0] cap_dout [4];
    logic        cap_cs   [4];

    always #5 clk = ~clk;

    sizing_bus_ctrl u_sizing_bus_ctrl (
        .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_word(req_word),
        .req_addr(req_addr), .req_wdata(req_wdata), .cfg_iack_en(cfg_iack_en),
        .cfg_iack_wait(cfg_iack_wait), .done(done), .rdata(rdata), .berr(berr),
        .bus_addr(bus_addr), .bus_strb_n(bus_strb_n), .bus_rd(bus_rd),
        .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_cs_n(bus_cs_n),
        .bus_din(bus_din), .end8_n(end8_n), .end16_n(end16_n)
    );

    function automatic logic [7:0] fb(input logic [15:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction

    // Device model: byte port answers on 15:8 with junk on 7:0.
    assign bus_din = (mode == 0) ? {fb(bus_addr), 8'hEE}
                                 : {fb({bus_addr[15:1], 1'b0}), fb({bus_addr[15:1], 1'b1})};

    always @(negedge clk) begin
        if (!bus_strb_n) begin
            if (dcnt == 0 && ncap < 4) begin
                cap_addr[ncap] = bus_addr;
                cap_dout[ncap] = bus_dout;
                cap_cs[ncap]   = bus_cs_n;
                ncap++;
            end
            end8_n  = !((mode == 0 || mode == 2) && dcnt == mwait);
            end16_n = !((mode == 1 || mode == 2) && dcnt == mwait);
            dcnt++;
        end else begin
            dcnt = 0;
            end8_n = 1'b1;
            end16_n = 1'b1;
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        int lat;
        int exp_lat, exp_cyc;
        logic exp_berr;
        logic [15:0] exp_rd, ea;
        string tg;
        @(negedge clk);
        mode = v.mode; mwait = v.wt; ncap = 0;
        cfg_iack_en = v.iack; cfg_iack_wait = v.iwt;
        req = 1'b1; req_we = v.we; req_word = v.word;
        req_addr = v.addr; req_wdata = v.wdata;
        lat = 0;
        while (lat < 200) begin
            @(negedge clk);
            req = 1'b0;
            lat++;
            if (done) break;
        end
        ea       = v.word ? {v.addr[15:1], 1'b0} : v.addr;
        exp_cyc  = (v.word && v.mode == 0 && !v.iack) ? 2 : 1;
        exp_berr = !v.iack && v.mode == 3;
        if (v.iack)                      exp_lat = v.iwt + 2;
        else if (v.mode == 3)            exp_lat = 65;
        else if (v.word && v.mode == 0)  exp_lat = 4 + 2 * v.wt;
        else                             exp_lat = 2 + v.wt;
        if (v.we || exp_berr) exp_rd = 16'h0000;
        else if (v.word)      exp_rd = {fb(ea), fb(ea | 16'h1)};
        else                  exp_rd = {8'h00, fb(ea)};
        if (v.iack)                  tg = "R7";
        else if (exp_berr)           tg = "R8";
        else if (v.mode == 2)        tg = "R5";
        else if (v.word && v.mode == 0) tg = "R2";
        else if (v.word)             tg = "R1";
        else                         tg = "R3";

        chk(done, "R6", "done seen", int'(done), 1);
        chk(lat == exp_lat, (exp_cyc == 2) ? "R12" : "R6", "latency", lat, exp_lat);
        chk(berr == exp_berr, "R8", "berr", int'(berr), int'(exp_berr));
        chk(ncap == exp_cyc, tg, "bus cycles", ncap, exp_cyc);
        if (!v.we) chk(rdata == exp_rd, tg, "rdata", int'(rdata), int'(exp_rd));
        chk(cap_addr[0] == ea, "R11", "first address", int'(cap_addr[0]), int'(ea));
        chk(cap_cs[0] == (ea[15:12] != 4'hF), "R7", "region select",
            int'(cap_cs[0]), int'(ea[15:12] != 4'hF));
        if (exp_cyc == 2)
            chk(cap_addr[1] == (ea | 16'h1), "R2", "second address",
                int'(cap_addr[1]), int'(ea | 16'h1));
        if (v.we) begin
            if (!v.word)
                chk(cap_dout[0] == {v.wdata[7:0], v.wdata[7:0]}, "R4", "byte write lanes",
                    int'(cap_dout[0]), int'({v.wdata[7:0], v.wdata[7:0]}));
            else
                chk(cap_dout[0] == v.wdata, "R4", "word write lanes",
                    int'(cap_dout[0]), int'(v.wdata));
            if (exp_cyc == 2)
                chk(cap_dout[1][15:8] == v.wdata[7:0], "R4", "second half byte",
                    int'(cap_dout[1][15:8]), int'(v.wdata[7:0]));
        end
        @(negedge clk);
        chk(!done, "R10", "done single pulse", int'(done), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(bus_strb_n && !done && !bus_doe && bus_cs_n, "R10", "reset idle",
            int'({bus_strb_n, done, bus_doe, bus_cs_n}), 4'b1001);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R9: a request during a transfer must not start another.
        @(negedge clk);
        mode = 1; mwait = 6; ncap = 0; cfg_iack_en = 1'b0;
        req = 1'b1; req_we = 1'b0; req_word = 1'b1; req_addr = 16'h0900;
        @(negedge clk); req = 1'b0;
        @(negedge clk);
        req = 1'b1; req_we = 1'b1; req_word = 1'b0; req_addr = 16'h0A00; req_wdata = 16'h0077;
        @(negedge clk); req = 1'b0;
        while (!done) @(negedge clk);
        chk(rdata == {fb(16'h0900), fb(16'h0901)}, "R9", "busy rdata",
            int'(rdata), int'({fb(16'h0900), fb(16'h0901)}));
        repeat (4) @(negedge clk);
        chk(ncap == 1 && cap_addr[0] == 16'h0900, "R9", "busy request ignored",
            ncap, 1);
        chk(bus_strb_n, "R9", "idle after busy request", int'(bus_strb_n), 1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule